// File: doc/BRIEF.md
# CPU-Fair Bus Master Arbiter

This arbiter hands one shared bus to either a CPU requester or one of several peripheral bus masters. Peripheral masters take turns in round-robin order. The CPU gets a bounded wait: a 2-bit setting fixes how many peripheral transactions may finish while the CPU is waiting. The completion that reaches that number hands the bus to the CPU. This holds however many peripherals are queued and whenever the CPU raised its request.

Ownership changes only at two points: when the current owner pulses `xfer_done` to end its transaction, or when the bus has no owner. Each grant is a registered output. The grant for a decision appears one clock after the cycle in which the decision inputs were sampled.

Top module: `busarb_top`

## Requirements
- R1: After reset, no grant is asserted and `cpu_gnt`/`pm_gnt` stay low until a request arrives.
- R2: At most one of `cpu_gnt` and the bits of `pm_gnt` is high in any cycle.
- R3: While an owner holds the bus, grants do not change until `xfer_done` is high. A `xfer_done` pulse while no one owns the bus is ignored.
- R4: When the bus has no owner, a request is granted on the next clock edge. With no requests, the bus stays without an owner.
- R5: Peripheral masters are granted round-robin. The search starts at the index after the last granted peripheral and wraps around. Index 0 is first after reset.
- R6: `rot_sel` encodes the CPU wait limit as follows: 2'b01 = 1, 2'b10 = 2, 2'b11 = 3, and 2'b00 = 3. A waiting CPU is granted at the peripheral completion that brings the count of completions seen while it waits up to the limit. The transaction running when the CPU raised its request counts as the first one.
- R7: Only peripheral completions that occur while `cpu_req` is high are counted. A cycle with `cpu_req` low clears the count.
- R8: A pending CPU request is granted at once, below the limit, when no peripheral master is requesting at the decision point.
- R9: Granting the CPU restarts its count at zero. When the CPU finishes, waiting peripherals are served before the CPU again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU bus request |
| cpu_gnt | output | 1 | CPU owns the bus |
| pm_req | input | NUM_PM | Peripheral master requests, one bit per master |
| pm_gnt | output | NUM_PM | Peripheral master grants, one-hot or zero |
| xfer_done | input | 1 | Current owner finished its transaction |
| rot_sel | input | 2 | CPU wait limit code |

## Verification
The bench tries every wait-limit code with all peripherals requesting. A counter that is off by one, or that forgets the running transaction, grants the CPU one completion early or late. It also drops `cpu_req` for one transaction in the middle of a wait. A design that keeps stale counts then grants the CPU too early. Other tests cover round-robin with sparse request patterns, so a pointer that restarts at 0 or skips a master shows up as a wrong index. Further tests cover the CPU being granted when no peripheral is requesting, and grants held steady across cycles without a completion. A last test sends stray completion pulses while the bus is idle: a design that acts on them would move the round-robin pointer or grant spuriously.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_PER  = 2'd2
    } owner_e;

    // Decode of the wait-limit setting; code 0 falls back to the widest bound.
    function automatic logic [1:0] wait_limit(input logic [1:0] sel);
        return (sel == 2'd0) ? 2'd3 : sel;
    endfunction

endpackage

// File: rtl/busarb_rr_pick.sv
module busarb_rr_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          any_o,
    output logic [IW-1:0] pick_o
);

    always_comb begin
        any_o  = 1'b0;
        pick_o = '0;
        for (int unsigned off = 1; off <= N; off++) begin
            int unsigned cand;
            cand = (int'(last_i) + off) % N;
            if (!any_o && req_i[cand]) begin
                any_o  = 1'b1;
                pick_o = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/busarb_wait_ctr.sv
module busarb_wait_ctr #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_i,
    input  logic          tick_i,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          due_o
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW:0]   cnt_next_sum;

    always_comb begin
        cnt_next_sum = {1'b0, cnt_q} + {{CW{1'b0}}, tick_i};
        due_o        = cpu_req_i && (cnt_next_sum >= {1'b0, limit_i});
        cnt_d        = cnt_q;
        if (!cpu_req_i || clear_i) begin
            cnt_d = '0;
        end else if (tick_i && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && !tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/busarb_top.sv
module busarb_top #(
    parameter int unsigned NUM_PM = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    output logic              cpu_gnt,
    input  logic [NUM_PM-1:0] pm_req,
    output logic [NUM_PM-1:0] pm_gnt,
    input  logic              xfer_done,
    input  logic [1:0]        rot_sel
);
    import busarb_pkg::*;

    localparam int unsigned IW = (NUM_PM > 1) ? $clog2(NUM_PM) : 1;
    localparam int unsigned CW = 2;

    typedef struct packed {
        owner_e        owner;
        logic [IW-1:0] idx;
        logic [IW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic          pm_any;
    logic [IW-1:0] pm_pick;
    logic          cpu_due;
    logic          busy, done_ev, decide, take_cpu;
    logic          ctr_tick, ctr_clear;

    busarb_rr_pick #(.N(NUM_PM), .IW(IW)) u_pick (
        .req_i  (pm_req),
        .last_i (st_q.ptr),
        .any_o  (pm_any),
        .pick_o (pm_pick)
    );

    busarb_wait_ctr #(.CW(CW)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req_i (cpu_req),
        .tick_i    (ctr_tick),
        .clear_i   (ctr_clear),
        .limit_i   (wait_limit(rot_sel)),
        .due_o     (cpu_due)
    );

    always_comb begin
        st_d      = st_q;
        busy      = (st_q.owner != OWN_NONE);
        done_ev   = busy && xfer_done;
        decide    = !busy || done_ev;
        ctr_tick  = done_ev && (st_q.owner == OWN_PER) && cpu_req;
        take_cpu  = cpu_req && (cpu_due || !pm_any);
        ctr_clear = decide && take_cpu;
        if (decide) begin
            if (take_cpu) begin
                st_d.owner = OWN_CPU;
            end else if (pm_any) begin
                st_d.owner = OWN_PER;
                st_d.idx   = pm_pick;
                st_d.ptr   = pm_pick;
            end else begin
                st_d.owner = OWN_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= OWN_NONE;
            st_q.idx   <= '0;
            st_q.ptr   <= IW'(NUM_PM - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_gnt = (st_q.owner == OWN_CPU);

    for (genvar g = 0; g < NUM_PM; g++) begin : g_gnt
        assign pm_gnt[g] = (st_q.owner == OWN_PER) && (st_q.idx == IW'(g));
    end

    // R2
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_gnt, pm_gnt}));

    // R3
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |=> $stable({cpu_gnt, pm_gnt}));

    // R6
    cpu_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && (st_q.owner == OWN_PER) && cpu_due) |=> cpu_gnt);

    // R8
    idle_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cpu_req && (pm_req == '0)) |=> cpu_gnt);

    // R5
    pick_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm_any |-> pm_req[pm_pick]);

endmodule

// File: tb/sim_busarb_top.sv
`timescale 1ns/100ps
module sim_busarb_top;

    localparam int NPM = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cpu_req = 1'b0;
    logic           cpu_gnt;
    logic [NPM-1:0] pm_req = '0;
    logic [NPM-1:0] pm_gnt;
    logic           xfer_done = 1'b0;
    logic [1:0]     rot_sel = 2'd1;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    busarb_top #(.NUM_PM(NPM)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_gnt(cpu_gnt),
        .pm_req(pm_req), .pm_gnt(pm_gnt), .xfer_done(xfer_done), .rot_sel(rot_sel)
    );

    localparam logic [NPM:0] GCPU = 5'b10000;
    localparam logic [NPM:0] GNONE = 5'b00000;

    function automatic logic [NPM:0] gpm(int i);
        return 5'(1 << i);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [NPM:0] exp);
        logic [NPM:0] got;
        got = {cpu_gnt, pm_gnt};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: grants got %b expected %b", req, got, exp);
        end
    endtask

    task automatic pulse_done();
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cpu_req = 1'b0; pm_req = '0; xfer_done = 1'b0; rot_sel = 2'd1;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset idle", GNONE);
        tick();
        chk("R1 still idle", GNONE);
    endtask

    task automatic t_idle();
        do_reset();
        pulse_done();
        chk("R3 done ignored when idle", GNONE);
        pm_req = 4'b0010;
        tick();
        chk("R4 idle grant pm1", gpm(1));
        pm_req = '0;
        pulse_done();
        chk("R4 back to idle", GNONE);
        cpu_req = 1'b1;
        tick();
        chk("R8 idle cpu grant", GCPU);
        cpu_req = 1'b0;
        pulse_done();
        chk("R4 idle after cpu", GNONE);
    endtask

    task automatic t_rr();
        do_reset();
        pm_req = 4'b1111;
        tick();
        chk("R5 first pm0", gpm(0));
        for (int k = 1; k <= 4; k++) begin
            pulse_done();
            chk("R5 rotation", gpm(k % 4));
        end
        pm_req = 4'b1010;
        pulse_done();
        chk("R5 sparse pm1", gpm(1));
        pulse_done();
        chk("R5 sparse pm3", gpm(3));
        pulse_done();
        chk("R5 sparse wrap pm1", gpm(1));
    endtask

    task automatic t_hold();
        do_reset();
        pm_req = 4'b0100;
        tick();
        chk("R4 grant pm2", gpm(2));
        cpu_req = 1'b1;
        pm_req = 4'b1111;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R3 hold without done", gpm(2));
        end
        pulse_done();
        chk("R6 setting1 cpu after current", GCPU);
    endtask

    task automatic t_rot(logic [1:0] sel, int lim);
        do_reset();
        rot_sel = sel;
        pm_req = 4'b1111;
        tick();
        chk("R6 start pm0", gpm(0));
        cpu_req = 1'b1;
        for (int k = 1; k < lim; k++) begin
            pulse_done();
            chk("R6 cpu still waiting", gpm(k));
        end
        pulse_done();
        chk("R6 cpu at limit", GCPU);
        cpu_req = 1'b0;
        pulse_done();
        chk("R9 peripheral after cpu", gpm(lim));
    endtask

    task automatic t_cnt_drop();
        do_reset();
        rot_sel = 2'd2;
        pm_req = 4'b1111;
        tick();
        cpu_req = 1'b1;
        pulse_done();
        chk("R7 first counted", gpm(1));
        cpu_req = 1'b0;
        pulse_done();
        chk("R7 not counted", gpm(2));
        cpu_req = 1'b1;
        pulse_done();
        chk("R7 count restarted", gpm(3));
        pulse_done();
        chk("R7 cpu after two", GCPU);
    endtask

    task automatic t_cpu_again();
        do_reset();
        rot_sel = 2'd1;
        pm_req = 4'b0001;
        cpu_req = 1'b1;
        tick();
        chk("R9 cpu alone not due with pm waiting", gpm(0));
        pulse_done();
        chk("R9 cpu granted", GCPU);
        pulse_done();
        chk("R9 pm served before cpu again", gpm(0));
    endtask

    task automatic t_nopm();
        do_reset();
        rot_sel = 2'd3;
        pm_req = 4'b0001;
        tick();
        cpu_req = 1'b1;
        pm_req = '0;
        pulse_done();
        chk("R8 cpu below limit, no pm", GCPU);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_rr();
        t_hold();
        t_rot(2'd1, 1);
        t_rot(2'd2, 2);
        t_rot(2'd3, 3);
        t_rot(2'd0, 3);
        t_cnt_drop();
        t_cpu_again();
        t_nopm();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule